// File: doc/BRIEF.md
# Prescaled Time Base Counter

This block keeps a 64-bit time value for a 32-bit processor core. A prescaler splits the bus clock so that the count moves forward at most once every four bus-clock cycles. An external enable pin decides whether each of those ticks is counted or dropped. Carries from the lower word into the upper word happen on the same tick, so the two words act as one 64-bit register.

Software cannot read all 64 bits in one access. Each read returns one 32-bit word, either the lower or the upper, and is driven by a decoded read request. Two function codes reach this read path, and the decoder treats them as the same code. Reads carry no privilege check. A write port can load either word, but only when the core asserts its write-allowed qualifier.

Top module: `tbase_counter`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears the 64-bit count, the prescaler phase, `rd_valid` and `rd_data` to zero.
- R2: The prescaler phase runs freely and issues one tick every PRESCALE (default 4) clock cycles whether `tb_en` is high or low. After reset is released, the first tick falls in the fourth cycle, so a counted tick shows in the count from the fourth rising edge after release.
- R3: A tick adds one to the count only when `tb_en` is high in the cycle of the tick. If no tick is counted and no write is accepted, the count keeps its value.
- R4: When a counted tick finds the lower word all ones, the lower word becomes zero and the upper word gains one at the same edge.
- R5: A counted tick that finds all 64 bits at one wraps the count to zero and raises no flag.
- R6: A request accepted at a clock edge drives `rd_valid` high for exactly the next cycle. `rd_data` then holds the word that was in place just before that edge: the lower word when `rd_sel` = 0 and the upper word when `rd_sel` = 1.
- R7: A request is accepted only if `rd_req` is high and the 10-bit `rd_func` equals 339 or 371. These two codes differ only in bit 5, and the decoder ignores that bit. For any other code `rd_valid` stays low and `rd_data` keeps its previous value.
- R8: Reads have no privilege check. The state of `wr_allow` has no effect on whether a read is accepted or on the data it returns.
- R9: A write loads `wr_data` into the lower word (`wr_sel` = 0) or the upper word (`wr_sel` = 1), but only when `wr_en` and `wr_allow` are both high. If `wr_allow` is low the write has no effect.
- R10: If a write and a counted tick reach the same word in the same cycle, the write wins for that word. The other word still follows R3 and R4, and any carry is taken from the lower word as it was before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| tb_en | input | 1 | Count enable, sampled at each tick |
| rd_req | input | 1 | Read request strobe |
| rd_func | input | 10 | Function code of the read request |
| rd_sel | input | 1 | Word select for reads: 0 lower, 1 upper |
| wr_en | input | 1 | Write request strobe |
| wr_allow | input | 1 | Write-allowed qualifier from the core |
| wr_sel | input | 1 | Word select for writes: 0 lower, 1 upper |
| wr_data | input | 32 | Write data |
| rd_valid | output | 1 | High for one cycle after an accepted read |
| rd_data | output | 32 | Returned word, held between reads |

## Verification
The assertions assume `rst` is held high for at least one clock edge before any check applies. They also assume all inputs are stable at the rising edge. The bench meets both: it starts in reset and drives every input on the falling edge. A reference model updates at each rising edge and gives the expected word. The stimulus runs through every one of the 1024 function codes, preloads words so that carry and full wrap come within a few ticks, makes writes land on tick cycles, and toggles `tb_en` and `wr_allow` from a pseudo-random sequence.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
   localparam int unsigned FUNC_W      = 10;
   localparam logic [FUNC_W-1:0] FUNC_READ = 10'd371;
   localparam logic [FUNC_W-1:0] FUNC_DONTCARE = 10'b00_0010_0000;

   typedef enum logic {
      WORD_LO = 1'b0,
      WORD_HI = 1'b1
   } word_sel_e;
endpackage

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
   parameter int unsigned PRESCALE = 4
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   initial begin
      if (PRESCALE < 1) $error("PRESCALE must be at least 1");
   end

   generate
      if (PRESCALE == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_divide
         localparam int unsigned PH_W = $clog2(PRESCALE);
         localparam logic [PH_W-1:0] PH_LAST = PH_W'(PRESCALE - 1);
         logic [PH_W-1:0] phase;

         always_ff @(posedge clk) begin
            if (rst) phase <= '0;
            else if (phase == PH_LAST) phase <= '0;
            else phase <= phase + 1'b1;
         end

         assign tick = (phase == PH_LAST);

         AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
            tick |=> !tick); // R2
         AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
            (phase != PH_LAST) |=> (phase == $past(phase) + 1'b1)); // R2
      end
   endgenerate
endmodule

// File: rtl/tbase_core.sv
module tbase_core #(
   parameter int unsigned HALF_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              inc,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [HALF_W-1:0] wr_data,
   output logic [HALF_W-1:0] cnt_lo,
   output logic [HALF_W-1:0] cnt_hi
);
   logic carry;

   assign carry = inc && (&cnt_lo);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_lo <= '0;
         cnt_hi <= '0;
      end else begin
         if (wr_lo)    cnt_lo <= wr_data;
         else if (inc) cnt_lo <= cnt_lo + 1'b1;
         if (wr_hi)      cnt_hi <= wr_data;
         else if (carry) cnt_hi <= cnt_hi + 1'b1;
      end
   end

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!inc && !wr_lo && !wr_hi) |=> $stable({cnt_hi, cnt_lo})); // R3
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
      (inc && !wr_lo && !wr_hi) |=> ({cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) + 1'b1)); // R4
   AST_FULL_WRAP: assert property (@(posedge clk) disable iff (rst)
      (inc && !wr_lo && !wr_hi && (&{cnt_hi, cnt_lo})) |=> ({cnt_hi, cnt_lo} == '0)); // R5
   AST_LOAD_LO: assert property (@(posedge clk) disable iff (rst)
      wr_lo |=> (cnt_lo == $past(wr_data))); // R10
   AST_LOAD_HI: assert property (@(posedge clk) disable iff (rst)
      wr_hi |=> (cnt_hi == $past(wr_data))); // R10
endmodule

// File: rtl/tbase_readport.sv
module tbase_readport
   import tbase_pkg::*;
#(
   parameter int unsigned HALF_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req,
   input  logic [FUNC_W-1:0] func,
   input  logic              sel,
   input  logic [HALF_W-1:0] cnt_lo,
   input  logic [HALF_W-1:0] cnt_hi,
   output logic              valid,
   output logic [HALF_W-1:0] data
);
   localparam logic [FUNC_W-1:0] CARE = ~FUNC_DONTCARE;
   logic hit;

   assign hit = req && ((func & CARE) == (FUNC_READ & CARE));

   always_ff @(posedge clk) begin
      if (rst) begin
         valid <= 1'b0;
         data  <= '0;
      end else begin
         valid <= hit;
         if (hit) data <= (word_sel_e'(sel) == WORD_HI) ? cnt_hi : cnt_lo;
      end
   end

   AST_RD_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
      hit |=> valid); // R6
   AST_RD_WORD: assert property (@(posedge clk) disable iff (rst)
      (hit && !sel) |=> (data == $past(cnt_lo))); // R6
   AST_RD_IGNORED: assert property (@(posedge clk) disable iff (rst)
      !hit |=> (!valid && $stable(data))); // R7
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
   import tbase_pkg::*;
#(
   parameter int unsigned CNT_W    = 64,
   parameter int unsigned PRESCALE = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 tb_en,
   input  logic                 rd_req,
   input  logic [FUNC_W-1:0]    rd_func,
   input  logic                 rd_sel,
   input  logic                 wr_en,
   input  logic                 wr_allow,
   input  logic                 wr_sel,
   input  logic [CNT_W/2-1:0]   wr_data,
   output logic                 rd_valid,
   output logic [CNT_W/2-1:0]   rd_data
);
   localparam int unsigned HALF_W = CNT_W / 2;

   generate
      if (CNT_W % 2 != 0 || CNT_W < 4) begin : g_bad_width
         initial $error("CNT_W must be even and at least 4");
      end
   endgenerate

   logic              tick;
   logic              inc;
   logic              wr_ok;
   logic              wr_lo;
   logic              wr_hi;
   logic [HALF_W-1:0] cnt_lo;
   logic [HALF_W-1:0] cnt_hi;

   assign inc   = tick && tb_en;
   assign wr_ok = wr_en && wr_allow;
   assign wr_lo = wr_ok && (word_sel_e'(wr_sel) == WORD_LO);
   assign wr_hi = wr_ok && (word_sel_e'(wr_sel) == WORD_HI);

   tbase_prescaler #(.PRESCALE(PRESCALE)) prescaler_i (
      .clk  (clk),
      .rst  (rst),
      .tick (tick)
   );

   tbase_core #(.HALF_W(HALF_W)) core_i (
      .clk     (clk),
      .rst     (rst),
      .inc     (inc),
      .wr_lo   (wr_lo),
      .wr_hi   (wr_hi),
      .wr_data (wr_data),
      .cnt_lo  (cnt_lo),
      .cnt_hi  (cnt_hi)
   );

   tbase_readport #(.HALF_W(HALF_W)) readport_i (
      .clk    (clk),
      .rst    (rst),
      .req    (rd_req),
      .func   (rd_func),
      .sel    (rd_sel),
      .cnt_lo (cnt_lo),
      .cnt_hi (cnt_hi),
      .valid  (rd_valid),
      .data   (rd_data)
   );

   AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (rst)
      (tick && !tb_en && !wr_ok) |=> $stable({cnt_hi, cnt_lo})); // R3
   AST_WRITE_GATED: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_allow && !inc) |=> $stable({cnt_hi, cnt_lo})); // R9
   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (!rd_valid && rd_data == '0 && cnt_lo == '0 && cnt_hi == '0)); // R1
endmodule

// File: tb/tbase_counter_tb_top.sv
module tbase_counter_tb_top;
   logic        clk = 1'b0;
   logic        rst, tb_en, rd_req, rd_sel, wr_en, wr_allow, wr_sel;
   logic [9:0]  rd_func;
   logic [31:0] wr_data;
   logic        rd_valid;
   logic [31:0] rd_data;

   int checks = 0;
   int errors = 0;
   string tag = "R1";
   logic [15:0] lfsr = 16'hACE1;

   always #4 clk = ~clk;

   tbase_counter dut_i (
      .clk(clk), .rst(rst), .tb_en(tb_en), .rd_req(rd_req), .rd_func(rd_func),
      .rd_sel(rd_sel), .wr_en(wr_en), .wr_allow(wr_allow), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   // Reference model built from the requirements
   logic [1:0]  m_ph;
   logic [63:0] m_cnt;
   logic        m_rv;
   logic [31:0] m_rd;

   function automatic logic func_ok(input logic [9:0] f);
      return (f == 10'd339) || (f == 10'd371);
   endfunction

   always @(posedge clk) begin
      logic inc, wl, wh, cy;
      logic [31:0] lo, hi;
      if (rst) begin
         m_ph <= 2'd0; m_cnt <= 64'd0; m_rv <= 1'b0; m_rd <= 32'd0;
      end else begin
         inc = (m_ph == 2'd3) && tb_en;
         wl  = wr_en && wr_allow && !wr_sel;
         wh  = wr_en && wr_allow && wr_sel;
         lo  = m_cnt[31:0];
         hi  = m_cnt[63:32];
         cy  = inc && (lo == 32'hFFFF_FFFF);
         m_rv <= rd_req && func_ok(rd_func);
         if (rd_req && func_ok(rd_func)) m_rd <= rd_sel ? hi : lo;
         m_cnt[31:0]  <= wl ? wr_data : (inc ? lo + 32'd1 : lo);
         m_cnt[63:32] <= wh ? wr_data : (cy ? hi + 32'd1 : hi);
         m_ph <= m_ph + 2'd1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      check(tag, {31'd0, rd_valid}, {31'd0, m_rv});
      check(tag, rd_data, m_rd);
   endtask

   task automatic idle();
      rd_req = 0; wr_en = 0;
   endtask

   task automatic wr(input logic sel, input logic [31:0] d);
      wr_en = 1; wr_allow = 1; wr_sel = sel; wr_data = d; rd_req = 0;
      cyc();
      wr_en = 0;
   endtask

   task automatic rd(input logic sel);
      rd_req = 1; rd_func = 10'd371; rd_sel = sel;
      cyc();
   endtask

   task automatic step_lfsr();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst = 1; tb_en = 0; rd_req = 0; rd_sel = 0; wr_en = 0; wr_allow = 0;
      wr_sel = 0; rd_func = 10'd0; wr_data = 32'd0;
      // R1: reset state
      tag = "R1";
      cyc(); cyc();
      check("R1", {31'd0, rd_valid}, 32'd0);
      check("R1", rd_data, 32'd0);
      rst = 0;
      rd(0); rd(1);
      // R2: first tick timing and period, enable high
      rst = 1; idle(); cyc(); rst = 0;
      tag = "R2"; tb_en = 1;
      for (int i = 0; i < 16; i++) rd(0);
      // R3: enable pattern
      tag = "R3";
      for (int i = 0; i < 200; i++) begin
         step_lfsr(); tb_en = lfsr[0] & lfsr[3];
         rd(lfsr[5] & lfsr[6]);
      end
      tb_en = 0;
      for (int i = 0; i < 8; i++) rd(0);
      // R4: carry into upper word
      tag = "R4"; tb_en = 1;
      wr(0, 32'hFFFF_FFFD); wr(1, 32'h0000_0005);
      for (int i = 0; i < 24; i++) rd(i[0]);
      // R5: full wrap
      tag = "R5";
      wr(0, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF);
      for (int i = 0; i < 12; i++) rd(i[0]);
      // R7: every function code
      tag = "R7";
      for (int f = 0; f < 1024; f++) begin
         rd_req = 1; rd_func = 10'(f); rd_sel = f[1];
         cyc();
      end
      idle();
      // R8: reads with write-allowed low and high
      tag = "R8";
      for (int i = 0; i < 32; i++) begin
         wr_allow = i[1]; rd(i[0]);
      end
      // R9: gated writes then accepted writes
      tag = "R9";
      wr_en = 1; wr_allow = 0; wr_sel = 0; wr_data = 32'h1234_5678; rd_req = 0;
      cyc(); wr_sel = 1; cyc(); wr_en = 0;
      rd(0); rd(1);
      wr(0, 32'hA5A5_0000); wr(1, 32'h0F0F_F0F0);
      rd(0); rd(1);
      // R10: writes colliding with ticks
      tag = "R10"; tb_en = 1;
      for (int i = 0; i < 8; i++) begin
         wr_en = 1; wr_allow = 1; wr_sel = 0; wr_data = 32'hFFFF_FFFF;
         rd_req = 1; rd_func = 10'd339; rd_sel = 1;
         cyc();
      end
      for (int i = 0; i < 8; i++) begin
         wr_en = 1; wr_allow = 1; wr_sel = 1; wr_data = 32'h0000_0100 + 32'(i);
         rd_req = 1; rd_func = 10'd339; rd_sel = i[0];
         cyc();
      end
      idle();
      // R6: long mixed sequence
      tag = "R6";
      for (int i = 0; i < 3000; i++) begin
         step_lfsr();
         tb_en    = lfsr[0] | lfsr[1];
         rd_req   = lfsr[2] | lfsr[9];
         rd_sel   = lfsr[3];
         case (lfsr[5:4])
            2'd0: rd_func = 10'd339;
            2'd1: rd_func = 10'd371;
            2'd2: rd_func = 10'd371 ^ 10'(1 << lfsr[8:6]);
            default: rd_func = lfsr[15:6];
         endcase
         wr_en    = (lfsr[12:10] == 3'd0);
         wr_allow = lfsr[13];
         wr_sel   = lfsr[14];
         wr_data  = (lfsr[15]) ? 32'hFFFF_FFFE : {lfsr, lfsr};
         cyc();
      end
      idle();
      rd(0); rd(1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule